// File: doc/BRIEF.md
# Memory Activity Sampling Monitor

This block measures how busy a memory controller is over a sample window. While collection runs, one counter advances on every controller clock and a second one advances only on clocks where a memory access is present. Collection stops by itself once the running total reaches a programmed cycle limit. It can also be stopped on command. After a stop the readings stay frozen for readback.

Software drives it through a small write port with three registers: a gather command, a cycle limit and a memory configuration word. The configuration sets a power-of-two scale exponent. The scale reflects that one active reading stands for several controller clocks, depending on DRAM kind and bus width. From the current readings the block continuously presents an idle count. The idle count is the total minus the scaled active count, and it floors at zero. Software normally programs the limit as the interval in milliseconds times the clock rate in kHz, plus 8. The extra 8 centres the 0 to 16 cycle uncertainty of the window end.

The controller is a four-state machine:
- `ST_IDLE` is entered after reset and on the reset or clear command.
- `ST_RUN` is entered on the enable command from any state.
- `ST_HALT` is entered on the disable command from any state.
- `ST_DONE` is entered from `ST_RUN` when the limit is reached.

Top module: `mem_busy_monitor`

## Requirements
- R1: After asynchronous reset the outputs are as follows. Both counts are zero and the idle count is zero. `collecting` and `sample_done` are low. The scale exponent is 1 and `type_err` is low.
- R2: A write to address 0 carries a command in `wr_data[1:0]`. Code 0 (reset) zeroes both counts, sets the limit to all-ones and enters `ST_IDLE`. Code 1 (clear) zeroes both counts and enters `ST_IDLE`, keeps the limit and starts no collection. Every write takes effect at the clock edge that samples it.
- R3: Code 2 (enable) enters `ST_RUN`. From the next clock on, the total count rises by one per clock and the active count rises on each clock where `mem_access` is high. Counting continues from the values held at that moment.
- R4: A write to address 1 sets the limit. In `ST_RUN`, the clock that brings the total to the limit moves the block to `ST_DONE`. In that state `sample_done` is high and both counts are held. If the total is already at or above the limit, the next clock enters `ST_DONE` without counting.
- R5: Code 3 (disable) enters `ST_HALT`. No count changes while the block stays there.
- R6: A clock with a command write never counts, whatever the command.
- R7: A write to address 2 sets `wr_data[1:0]` as the DRAM kind (0, 1 and 2 are supported) and `wr_data[2]` as 16-bit width. For a supported kind the scale becomes 1 plus the width bit and `type_err` clears. Code 3 sets `type_err` and leaves the scale unchanged.
- R8: `idle_cycles` equals the total minus (active shifted left by the scale). It is 0 when the scaled active count is not smaller than the total.
- R9: The counts never wrap. With the limit at all-ones the total stops at all-ones.
- R10: A write to address 3 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 limit, 2 memory config |
| wr_data | input | CNT_W | Write data |
| mem_access | input | 1 | High on clocks with a memory access |
| total_cycles | output | CNT_W | Total-cycle reading |
| active_cycles | output | CNT_W | Active-cycle reading |
| idle_cycles | output | CNT_W | Derived idle count |
| scale_exp | output | 2 | Active-count scale exponent |
| collecting | output | 1 | High in `ST_RUN` |
| sample_done | output | 1 | High in `ST_DONE` |
| type_err | output | 1 | Last memory config named an unsupported kind |

## Verification
The bench builds the block with a 10-bit count width, in place of the default 24. At that width an all-ones limit is reached in about a thousand clocks, so the no-wrap stop at full scale is exercised directly. The narrow width also lets random limits and random command mixes drive the total past the limit and push the scaled active count above the total, which makes the idle floor at zero common. The scale exponent of 2 is covered too.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

    typedef enum logic [1:0] {
        CMD_RESET   = 2'd0,
        CMD_CLEAR   = 2'd1,
        CMD_ENABLE  = 2'd2,
        CMD_DISABLE = 2'd3
    } gather_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2,
        ST_DONE = 2'd3
    } mon_state_e;

    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_LIMIT  = 2'd1;
    localparam logic [1:0] ADDR_MEMCFG = 2'd2;

    localparam logic [1:0] KIND_UNSUPPORTED = 2'd3;

    localparam int SCALE_W = 2;
    localparam logic [SCALE_W-1:0] SCALE_RESET = 2'd1;

endpackage

// File: rtl/mbm_regs.sv
module mbm_regs
    import mbm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic               cmd_valid,
    output gather_cmd_e        cmd,
    output logic [CNT_W-1:0]   limit_q,
    output logic [SCALE_W-1:0] scale_q,
    output logic               type_err_q
);

    logic       limit_wr;
    logic       cfg_wr;
    logic [1:0] kind;
    logic       wide16;

    assign cmd_valid = wr_en && (wr_addr == ADDR_MODE);
    assign cmd       = gather_cmd_e'(wr_data[1:0]);
    assign limit_wr  = wr_en && (wr_addr == ADDR_LIMIT);
    assign cfg_wr    = wr_en && (wr_addr == ADDR_MEMCFG);
    assign kind      = wr_data[1:0];
    assign wide16    = wr_data[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '1;
        end else if (cmd_valid && cmd == CMD_RESET) begin
            limit_q <= '1;
        end else if (limit_wr) begin
            limit_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q    <= SCALE_RESET;
            type_err_q <= 1'b0;
        end else if (cfg_wr) begin
            if (kind == KIND_UNSUPPORTED) begin
                type_err_q <= 1'b1;
            end else begin
                type_err_q <= 1'b0;
                scale_q    <= SCALE_RESET + SCALE_W'(wide16);
            end
        end
    end

    // R7: an unsupported kind flags an error and keeps the scale
    a_r7_bad_kind_keeps_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MEMCFG && wr_data[1:0] == 2'd3)
        |=> ($stable(scale_q) && type_err_q));

    // R2: the reset command restores the full-scale limit
    a_r2_reset_limit_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MODE && wr_data[1:0] == 2'd0)
        |=> (limit_q == '1));

endmodule

// File: rtl/mbm_ctrl_fsm.sv
module mbm_ctrl_fsm
    import mbm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  gather_cmd_e      cmd,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] limit,
    output mon_state_e       state,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             collecting,
    output logic             done
);

    mon_state_e nxt;
    logic       room;
    logic       last;

    assign room = total < limit;
    assign last = ({1'b0, total} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (cmd_valid) begin
            unique case (cmd)
                CMD_RESET, CMD_CLEAR: nxt = ST_IDLE;
                CMD_ENABLE:           nxt = ST_RUN;
                CMD_DISABLE:          nxt = ST_HALT;
                default:              nxt = state;
            endcase
        end else begin
            unique case (state)
                ST_RUN:  if (!room || last) nxt = ST_DONE;
                ST_IDLE: nxt = ST_IDLE;
                ST_HALT: nxt = ST_HALT;
                ST_DONE: nxt = ST_DONE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cnt_clr    = cmd_valid && (cmd == CMD_RESET || cmd == CMD_CLEAR);
        cnt_inc    = 1'b0;
        collecting = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_RUN: begin
                collecting = 1'b1;
                cnt_inc    = !cmd_valid && room;
            end
            ST_DONE: done = 1'b1;
            ST_IDLE, ST_HALT: ;
            default: ;
        endcase
    end

    // R4: completion follows a run with no command in the way
    a_r4_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == ST_RUN && !$past(cmd_valid)));

    // R6: a command clock never advances the counters
    a_r6_cmd_blocks_count: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cnt_inc);

endmodule

// File: rtl/mbm_sat_counter.sv
module mbm_sat_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count <= '0;
        else if (clr)                   count <= '0;
        else if (inc && count != TOP)   count <= count + 1'b1;
    end

    // R9: a full counter never wraps back to zero
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && count == TOP) |=> (count == TOP));

endmodule

// File: rtl/mbm_idle_calc.sv
module mbm_idle_calc #(
    parameter int CNT_W   = 24,
    parameter int SCALE_W = 2
) (
    input  logic [CNT_W-1:0]   total,
    input  logic [CNT_W-1:0]   active,
    input  logic [SCALE_W-1:0] scale,
    output logic [CNT_W-1:0]   idle
);

    localparam int SW = CNT_W + (1 << SCALE_W) - 1;

    logic [SW-1:0] scaled;
    logic [SW-1:0] total_w;

    assign scaled  = SW'(active) << scale;
    assign total_w = SW'(total);

    always_comb begin
        if (total_w > scaled) idle = CNT_W'(total_w - scaled);
        else                  idle = '0;
    end

    // R8: the derived idle count never exceeds the total
    a_r8_idle_bounded: assert final (idle <= total);

endmodule

// File: rtl/mem_busy_monitor.sv
module mem_busy_monitor
    import mbm_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic               mem_access,
    output logic [CNT_W-1:0]   total_cycles,
    output logic [CNT_W-1:0]   active_cycles,
    output logic [CNT_W-1:0]   idle_cycles,
    output logic [SCALE_W-1:0] scale_exp,
    output logic               collecting,
    output logic               sample_done,
    output logic               type_err
);

    localparam int NCNT = 2;

    logic                       cmd_valid;
    gather_cmd_e                cmd;
    logic [CNT_W-1:0]           limit_q;
    mon_state_e                 state;
    logic                       cnt_clr;
    logic                       cnt_inc;
    logic [NCNT-1:0]            inc_v;
    logic [NCNT-1:0][CNT_W-1:0] cnt_q;

    mbm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .limit_q    (limit_q),
        .scale_q    (scale_exp),
        .type_err_q (type_err)
    );

    mbm_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .total      (cnt_q[0]),
        .limit      (limit_q),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .collecting (collecting),
        .done       (sample_done)
    );

    assign inc_v = {cnt_inc & mem_access, cnt_inc};

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        mbm_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (inc_v[g]),
            .count (cnt_q[g])
        );
    end

    assign total_cycles  = cnt_q[0];
    assign active_cycles = cnt_q[1];

    mbm_idle_calc #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_idle (
        .total  (total_cycles),
        .active (active_cycles),
        .scale  (scale_exp),
        .idle   (idle_cycles)
    );

    // R3: active clocks are a subset of total clocks
    a_r3_active_le_total: assert property (@(posedge clk) disable iff (!rst_n)
        active_cycles <= total_cycles);

    // R5: readings hold while halted and untouched
    a_r5_halt_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && !wr_en)
        |=> ($stable(total_cycles) && $stable(active_cycles)));

    // R4: readings hold after the window completes
    a_r4_done_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_done && !wr_en)
        |=> ($stable(total_cycles) && $stable(active_cycles) && sample_done));

    // R2: clear or reset command zeroes both readings
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MODE && wr_data[1] == 1'b0)
        |=> (total_cycles == '0 && active_cycles == '0));

endmodule

// File: tb/mem_busy_monitor_test.sv
module mem_busy_monitor_test;

    localparam int W    = 10;
    localparam int ONES = (1 << W) - 1;
    localparam int S_IDLE = 0, S_RUN = 1, S_HALT = 2, S_DONE = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         mem_access = 1'b0;
    logic [W-1:0] total_cycles, active_cycles, idle_cycles;
    logic [1:0]   scale_exp;
    logic         collecting, sample_done, type_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int mt = 0, ma = 0, ml = ONES, ms = 1, mst = S_IDLE;
    bit merr = 0;

    always #4 clk = ~clk;

    mem_busy_monitor #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mem_access(mem_access),
        .total_cycles(total_cycles), .active_cycles(active_cycles),
        .idle_cycles(idle_cycles), .scale_exp(scale_exp),
        .collecting(collecting), .sample_done(sample_done), .type_err(type_err)
    );

    function automatic int exp_idle(int t, int a, int s);
        int sc;
        sc = a << s;
        return (t > sc) ? t - sc : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model(bit we, int ad, int dat, bit acc);
        int  ot, ol;
        bit  cmdw;
        ot   = mt;
        ol   = ml;
        cmdw = we && ad == 0;
        if (mst == S_RUN && !cmdw) begin
            if (ot < ol) begin
                mt++;
                if (acc) ma++;
            end
            if (ot + 1 >= ol) mst = S_DONE;
        end
        if (we) begin
            case (ad)
                0: case (dat & 3)
                       0: begin mt = 0; ma = 0; ml = ONES; mst = S_IDLE; end
                       1: begin mt = 0; ma = 0; mst = S_IDLE; end
                       2: mst = S_RUN;
                       default: mst = S_HALT;
                   endcase
                1: ml = dat & ONES;
                2: if ((dat & 3) == 3) merr = 1;
                   else begin merr = 0; ms = 1 + ((dat >> 2) & 1); end
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        chk("R3 total", int'(total_cycles), mt);
        chk("R3 active", int'(active_cycles), ma);
        chk("R4 done", int'(sample_done), int'(mst == S_DONE));
        chk("R3 collecting", int'(collecting), int'(mst == S_RUN));
        chk("R8 idle", int'(idle_cycles), exp_idle(mt, ma, ms));
        chk("R7 scale", int'(scale_exp), ms);
        chk("R7 err", int'(type_err), int'(merr));
    endtask

    task automatic step(bit we, int ad, int dat, bit acc);
        wr_en      = we;
        wr_addr    = ad[1:0];
        wr_data    = dat[W-1:0];
        mem_access = acc;
        @(posedge clk);
        model(we, ad, dat, acc);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic idle_run(int n, bit acc);
        for (int i = 0; i < n; i++) step(0, 0, 0, acc);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int snap;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 total", int'(total_cycles), 0);
        chk("R1 active", int'(active_cycles), 0);
        chk("R1 idle", int'(idle_cycles), 0);
        chk("R1 collecting", int'(collecting), 0);
        chk("R1 done", int'(sample_done), 0);
        chk("R1 scale", int'(scale_exp), 1);
        chk("R1 err", int'(type_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 scale selection
        step(1, 2, 0, 0); chk("R7 ddr x32", int'(scale_exp), 1);
        step(1, 2, 6, 0); chk("R7 x16", int'(scale_exp), 2);
        step(1, 2, 3, 0); chk("R7 bad kind err", int'(type_err), 1);
        chk("R7 bad kind scale kept", int'(scale_exp), 2);
        step(1, 2, 1, 0); chk("R7 err cleared", int'(type_err), 0);

        // R4 window stops at limit
        step(1, 1, 20, 0); step(1, 0, 1, 0); step(1, 0, 2, 0);
        for (int i = 0; i < 25; i++) step(0, 0, 0, i[0]);
        chk("R4 total at limit", int'(total_cycles), 20);
        chk("R4 done high", int'(sample_done), 1);

        // R4 enable at or above limit
        step(1, 1, 5, 0); step(1, 0, 2, 1); step(0, 0, 0, 1);
        chk("R4 over limit no count", int'(total_cycles), 20);

        // R5 disable holds readings
        step(1, 1, 200, 0); step(1, 0, 1, 0); step(1, 0, 2, 0);
        idle_run(10, 1);
        step(1, 0, 3, 1);
        snap = int'(total_cycles);
        idle_run(6, 1);
        chk("R5 hold", int'(total_cycles), snap);

        // R6 command clock does not count
        step(1, 0, 2, 1); snap = int'(total_cycles);
        step(1, 0, 2, 1); chk("R6 re-enable no count", int'(total_cycles), snap);
        step(0, 0, 0, 1); chk("R6 counting resumes", int'(total_cycles), snap + 1);

        // R10 address 3 ignored
        step(1, 0, 3, 0); snap = int'(total_cycles);
        step(1, 3, 2, 1);
        chk("R10 no start", int'(collecting), 0);
        chk("R10 total", int'(total_cycles), snap);

        // R2 clear keeps the limit
        step(1, 1, 5, 0); step(1, 0, 1, 0);
        chk("R2 clear zero", int'(total_cycles), 0);
        step(1, 0, 2, 0); idle_run(10, 1);
        chk("R2 limit kept", int'(total_cycles), 5);

        // R9 full-scale stop, reset restores all-ones limit
        step(1, 0, 0, 0); step(1, 0, 2, 0);
        idle_run(ONES + 40, 1);
        chk("R9 total saturates", int'(total_cycles), ONES);
        chk("R9 active saturates", int'(active_cycles), ONES);
        chk("R8 idle floor", int'(idle_cycles), 0);

        // randomized mix
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 4)       step(1, 0, $urandom_range(0, 3), $urandom_range(0, 1));
            else if (r < 7)  step(1, 1, $urandom_range(0, 80), $urandom_range(0, 1));
            else if (r < 9)  step(1, 2, $urandom_range(0, 7), $urandom_range(0, 1));
            else if (r < 10) step(1, 3, $urandom_range(0, 7), $urandom_range(0, 1));
            else             step(0, 0, 0, ($urandom_range(0, 3) != 0));
        end

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule